// File: doc/BRIEF.md
# Configurable Register/Latch Macrocell

This block is one programmable storage cell for a programmable-logic fabric. It takes a logic sum from the term allocator or, as an alternative, a direct pad input. The logic path can be inverted. The result goes into a storage element that static configuration sets up as a D flip-flop, a toggle flip-flop or a level-transparent latch. The stored bit drives two routing outputs, one for local routing and one for global routing.

The clock is picked from eight sources:
- the block clocks;
- a shared product-term clock;
- an individual product-term clock, in true form;
- the same individual clock, in complement form;
- a tied-off source that never clocks.

The individual control term can serve as a clock enable, a reset term or a preset term. A separate shared initialization term can reset or preset the cell.

The whole cell runs from one fast system clock `clk`. The selected clock source is treated as a data level. A rising edge of that level is detected by comparing it with its value one system cycle earlier. The synchronous `rst` input models power-up initialization and loads a configured value into the cell.

Top module: `cfg_macrocell`

## Requirements
- R1: The data bit is `pad_in` when `cfg_use_pad`=1, and is then never inverted. Otherwise it is `sum_in` XOR `cfg_invert`.
- R2: `cfg_clk_sel` picks the clock source. Codes 0-3 select `blk_clk[0..3]`. Code 4 selects `pt_shr_clk`. Code 5 selects `pt_ind_clk`. Code 6 selects the inverse of `pt_ind_clk`, so a falling edge of that pin counts as a rising edge. Code 7 is tied low and never clocks the cell.
- R3: In D mode (`cfg_mode` 0, and the spare code 3) the cell takes the data bit on the system clock edge at which the selected source is first seen high after being low. The new value is visible after that edge. At all other times the cell holds.
- R4: In toggle mode (`cfg_mode` 1), a detected rising edge inverts the stored bit when the data bit is 1 and keeps it when the data bit is 0.
- R5: In latch mode (`cfg_mode` 2), the cell loads the data bit on every system clock edge while the selected source is high. While the source is low, the cell holds.
- R6: With `cfg_ind_use`=1, `pt_ind` is a clock enable. While it is low, no capture, toggle or latch load takes place.
- R7: Initialization terms act on the next system clock edge, whatever the clock source or enable is doing. `cfg_shr_act` 1 makes `pt_shr_init` a reset to 0, and 2 makes it a preset to 1 (0 and 3 give no action). `cfg_ind_use` 2 makes `pt_ind` a reset and 3 makes it a preset.
- R8: When a reset term and a preset term are active in the same cycle, the cell goes to 0. Reset also overrides a capture in that cycle.
- R9: While `rst` is high the cell loads `cfg_init_val`. A selected source that is already high when `rst` falls does not count as a rising edge.
- R10: `route_local` and `route_global` both carry the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up initialization |
| sum_in | input | 1 | Sum from the term allocator |
| pad_in | input | 1 | Direct pad input |
| blk_clk | input | NUM_BLK_CLK | Block clock levels |
| pt_shr_clk | input | 1 | Shared product-term clock level |
| pt_ind_clk | input | 1 | Individual product-term clock level |
| pt_shr_init | input | 1 | Shared initialization term |
| pt_ind | input | 1 | Individual control term (enable, reset or preset) |
| cfg_invert | input | 1 | Invert the logic-path data |
| cfg_use_pad | input | 1 | Take data from the pad input |
| cfg_mode | input | 2 | Storage mode: 0 D, 1 toggle, 2 latch, 3 D |
| cfg_clk_sel | input | SEL_W | Clock source code |
| cfg_shr_act | input | 2 | Shared term action: 1 reset, 2 preset |
| cfg_ind_use | input | 2 | Individual term role: 1 enable, 2 reset, 3 preset |
| cfg_init_val | input | 1 | Value loaded at power-up |
| route_local | output | 1 | Stored bit to local routing |
| route_global | output | 1 | Stored bit to global routing |

## Verification
The cell can see a rising edge of its clock source in the same cycle that both a reset term and a preset term are active. All three compete for the one stored bit.

The bench provokes this case in steps. It first drives the source low with data 1 in D mode. It then raises the source, the individual reset term and the shared preset term together. It expects 0, because reset beats both preset and capture. It then drops only the reset term and expects 1 from the preset alone.

A second collision occurs when power-up initialization ends while the selected source is already high. The bench checks that no capture follows.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    ST_DFF     = 2'd0,
    ST_TFF     = 2'd1,
    ST_LATCH   = 2'd2,
    ST_DFF_ALT = 2'd3
  } store_mode_e;

  typedef enum logic [1:0] {
    SHR_NONE     = 2'd0,
    SHR_RESET    = 2'd1,
    SHR_PRESET   = 2'd2,
    SHR_NONE_ALT = 2'd3
  } shr_act_e;

  typedef enum logic [1:0] {
    IND_IDLE   = 2'd0,
    IND_CE     = 2'd1,
    IND_RESET  = 2'd2,
    IND_PRESET = 2'd3
  } ind_use_e;

endpackage

// File: rtl/mcell_clk_pick.sv
module mcell_clk_pick #(
  parameter int NUM_BLK_CLK = 4,
  localparam int NUM_SRC = NUM_BLK_CLK + 4,
  localparam int SEL_W   = $clog2(NUM_SRC),
  localparam int NUM_PAD = 1 << SEL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_BLK_CLK-1:0] blk_clk,
  input  logic                   pt_shr_clk,
  input  logic                   pt_ind_clk,
  input  logic [SEL_W-1:0]       sel,
  output logic                   lvl_o,
  output logic                   rise_o
);

  logic [NUM_PAD-1:0] src;
  logic               prev_q;

  // block clocks occupy the low codes
  for (genvar gi = 0; gi < NUM_BLK_CLK; gi++) begin : g_blk
    assign src[gi] = blk_clk[gi];
  end

  assign src[NUM_BLK_CLK]     = pt_shr_clk;
  assign src[NUM_BLK_CLK + 1] = pt_ind_clk;
  assign src[NUM_BLK_CLK + 2] = ~pt_ind_clk;
  assign src[NUM_BLK_CLK + 3] = 1'b0;

  // unused codes when the source count is not a power of two
  for (genvar gp = NUM_SRC; gp < NUM_PAD; gp++) begin : g_pad
    assign src[gp] = 1'b0;
  end

  assign lvl_o = src[sel];

  // previous level starts high so a level already high after reset is no edge
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= lvl_o;
    end
  end

  assign rise_o = lvl_o & ~prev_q;

endmodule

// File: rtl/mcell_dpath.sv
module mcell_dpath (
  input  logic sum_in,
  input  logic pad_in,
  input  logic use_pad,
  input  logic invert,
  output logic d_o
);

  logic logic_bit;

  always_comb begin
    logic_bit = sum_in ^ invert;
    d_o       = use_pad ? pad_in : logic_bit;
  end

endmodule

// File: rtl/mcell_ctrl.sv
module mcell_ctrl
  import mcell_pkg::*;
(
  input  logic       shr_init,
  input  logic       ind_term,
  input  logic [1:0] shr_act,
  input  logic [1:0] ind_use,
  output logic       kill_o,
  output logic       force_o,
  output logic       en_o
);

  shr_act_e shr_mode;
  ind_use_e ind_mode;

  always_comb begin
    shr_mode = shr_act_e'(shr_act);
    ind_mode = ind_use_e'(ind_use);
    kill_o   = ((shr_mode == SHR_RESET)  && shr_init) ||
               ((ind_mode == IND_RESET)  && ind_term);
    force_o  = ((shr_mode == SHR_PRESET) && shr_init) ||
               ((ind_mode == IND_PRESET) && ind_term);
    en_o     = (ind_mode != IND_CE) || ind_term;
  end

endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       init_val,
  input  logic [1:0] mode,
  input  logic       d,
  input  logic       lvl,
  input  logic       rise,
  input  logic       en,
  input  logic       kill,
  input  logic       force1,
  output logic       q_o
);

  store_mode_e mode_e;
  logic        q_r;

  assign mode_e = store_mode_e'(mode);

  // priority: power-up, reset term, preset term, then gated clocking
  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= init_val;
    end else if (kill) begin
      q_r <= 1'b0;
    end else if (force1) begin
      q_r <= 1'b1;
    end else if (en) begin
      case (mode_e)
        ST_TFF: begin
          if (rise) q_r <= q_r ^ d;
        end
        ST_LATCH: begin
          if (lvl) q_r <= d;
        end
        default: begin
          if (rise) q_r <= d;
        end
      endcase
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/cfg_macrocell.sv
module cfg_macrocell #(
  parameter int NUM_BLK_CLK = 4,
  localparam int NUM_SRC = NUM_BLK_CLK + 4,
  localparam int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sum_in,
  input  logic                   pad_in,
  input  logic [NUM_BLK_CLK-1:0] blk_clk,
  input  logic                   pt_shr_clk,
  input  logic                   pt_ind_clk,
  input  logic                   pt_shr_init,
  input  logic                   pt_ind,
  input  logic                   cfg_invert,
  input  logic                   cfg_use_pad,
  input  logic [1:0]             cfg_mode,
  input  logic [SEL_W-1:0]       cfg_clk_sel,
  input  logic [1:0]             cfg_shr_act,
  input  logic [1:0]             cfg_ind_use,
  input  logic                   cfg_init_val,
  output logic                   route_local,
  output logic                   route_global
);

  logic sel_lvl;
  logic sel_rise;
  logic data_d;
  logic kill_lo;
  logic force_hi;
  logic en_ok;
  logic cell_q;

  mcell_clk_pick #(
    .NUM_BLK_CLK (NUM_BLK_CLK)
  ) u_clk (
    .clk        (clk),
    .rst        (rst),
    .blk_clk    (blk_clk),
    .pt_shr_clk (pt_shr_clk),
    .pt_ind_clk (pt_ind_clk),
    .sel        (cfg_clk_sel),
    .lvl_o      (sel_lvl),
    .rise_o     (sel_rise)
  );

  mcell_dpath u_dp (
    .sum_in  (sum_in),
    .pad_in  (pad_in),
    .use_pad (cfg_use_pad),
    .invert  (cfg_invert),
    .d_o     (data_d)
  );

  mcell_ctrl u_ctl (
    .shr_init (pt_shr_init),
    .ind_term (pt_ind),
    .shr_act  (cfg_shr_act),
    .ind_use  (cfg_ind_use),
    .kill_o   (kill_lo),
    .force_o  (force_hi),
    .en_o     (en_ok)
  );

  mcell_store u_st (
    .clk      (clk),
    .rst      (rst),
    .init_val (cfg_init_val),
    .mode     (cfg_mode),
    .d        (data_d),
    .lvl      (sel_lvl),
    .rise     (sel_rise),
    .en       (en_ok),
    .kill     (kill_lo),
    .force1   (force_hi),
    .q_o      (cell_q)
  );

  assign route_local  = cell_q;
  assign route_global = cell_q;

endmodule

// File: rtl/cfg_macrocell_chk.sv
module cfg_macrocell_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       init_val,
  input logic       lvl,
  input logic       rise,
  input logic       en,
  input logic       kill,
  input logic       force1,
  input logic       d,
  input logic       q
);

  // R9
  pwrup_load_chk: assert property (@(posedge clk)
    rst |=> (q == $past(init_val)));

  // R8
  reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> !q);

  // R7
  preset_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (force1 && !kill) |=> q);

  // R3
  dff_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd0 || mode == 2'd3) && rise && en && !kill && !force1)
      |=> (q == $past(d)));

  // R3
  dff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd0 || mode == 2'd3) && !rise && !kill && !force1)
      |=> $stable(q));

  // R4
  tff_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && rise && en && !kill && !force1)
      |=> (q == ($past(q) ^ $past(d))));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !lvl && !kill && !force1) |=> $stable(q));

  // R6
  enable_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !kill && !force1) |=> $stable(q));

endmodule

bind cfg_macrocell cfg_macrocell_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (cfg_mode),
  .init_val (cfg_init_val),
  .lvl      (sel_lvl),
  .rise     (sel_rise),
  .en       (en_ok),
  .kill     (kill_lo),
  .force1   (force_hi),
  .d        (data_d),
  .q        (route_local)
);

// File: tb/cfg_macrocell_test.sv
`timescale 1ns/1ps
module cfg_macrocell_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       sum_in, pad_in;
  logic [3:0] blk_clk;
  logic       pt_shr_clk, pt_ind_clk, pt_shr_init, pt_ind;
  logic       cfg_invert, cfg_use_pad, cfg_init_val;
  logic [1:0] cfg_mode, cfg_shr_act, cfg_ind_use;
  logic [2:0] cfg_clk_sel;
  logic       route_local, route_global;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  cfg_macrocell uut (
    .clk (clk), .rst (rst), .sum_in (sum_in), .pad_in (pad_in),
    .blk_clk (blk_clk), .pt_shr_clk (pt_shr_clk), .pt_ind_clk (pt_ind_clk),
    .pt_shr_init (pt_shr_init), .pt_ind (pt_ind),
    .cfg_invert (cfg_invert), .cfg_use_pad (cfg_use_pad),
    .cfg_mode (cfg_mode), .cfg_clk_sel (cfg_clk_sel),
    .cfg_shr_act (cfg_shr_act), .cfg_ind_use (cfg_ind_use),
    .cfg_init_val (cfg_init_val),
    .route_local (route_local), .route_global (route_global)
  );

  // fields: mode[9:8] sel[7:5] inv[4] use_pad[3] sum[2] pad[1] expected[0]
  localparam int NVEC = 14;
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd0, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd0, 3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'd1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd2, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd2, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd3, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // drive the source chosen by sel to level v; all other sources low
  task automatic set_lvl(input logic [2:0] sel, input logic v);
    blk_clk    = 4'b0000;
    pt_shr_clk = 1'b0;
    pt_ind_clk = 1'b0;
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: blk_clk[sel[1:0]] = v;
      3'd4: pt_shr_clk = v;
      3'd5: pt_ind_clk = v;
      3'd6: pt_ind_clk = ~v;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic exp);
    n_chk++;
    if (route_local !== exp || route_global !== exp) begin
      n_fail++;
      $display("FAIL %s: local=%b global=%b expected=%b",
               tag, route_local, route_global, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    sum_in = 1'b0; pad_in = 1'b0;
    blk_clk = 4'b0; pt_shr_clk = 1'b0; pt_ind_clk = 1'b0;
    pt_shr_init = 1'b0; pt_ind = 1'b0;
    cfg_invert = 1'b0; cfg_use_pad = 1'b0; cfg_init_val = 1'b0;
    cfg_mode = 2'd0; cfg_shr_act = 2'd0; cfg_ind_use = 2'd0;
    cfg_clk_sel = 3'd0;
    repeat (3) tick();
    check("R9 reset loads init value 0", 1'b0);
    rst = 1'b0;
    tick();

    // table walk: R1 data select/invert, R2 sources, R3 D, R4 toggle, R5 latch, R10 both outputs
    for (int i = 0; i < NVEC; i++) begin
      logic [9:0] v;
      v = VEC[i];
      cfg_mode    = v[9:8];
      cfg_clk_sel = v[7:5];
      cfg_invert  = v[4];
      cfg_use_pad = v[3];
      sum_in      = v[2];
      pad_in      = v[1];
      set_lvl(v[7:5], 1'b0);
      tick();
      set_lvl(v[7:5], 1'b1);
      tick();
      case (v[9:8])
        2'd1:    check($sformatf("R4 R1 R2 R10 vector %0d", i), v[0]);
        2'd2:    check($sformatf("R5 R1 R2 R10 vector %0d", i), v[0]);
        default: check($sformatf("R3 R1 R2 R10 vector %0d", i), v[0]);
      endcase
    end

    // R3: a level held high is not a new edge
    cfg_mode = 2'd0; cfg_clk_sel = 3'd0; cfg_invert = 1'b0; cfg_use_pad = 1'b0;
    sum_in = 1'b0;
    set_lvl(3'd0, 1'b1);
    tick(); tick();
    check("R3 hold while source stays high", 1'b1);
    set_lvl(3'd0, 1'b0);
    tick();
    check("R3 hold on falling source", 1'b1);

    // R2: code 7 never clocks
    cfg_clk_sel = 3'd7;
    blk_clk = 4'hF; pt_shr_clk = 1'b1; pt_ind_clk = 1'b1;
    tick();
    blk_clk = 4'h0; pt_shr_clk = 1'b0; pt_ind_clk = 1'b0;
    tick();
    blk_clk = 4'hF; pt_shr_clk = 1'b1; pt_ind_clk = 1'b1;
    tick();
    check("R2 tied-off source code 7", 1'b1);

    // R6: clock enable blocks then allows capture
    cfg_clk_sel = 3'd0; cfg_ind_use = 2'd1; pt_ind = 1'b0; sum_in = 1'b0;
    set_lvl(3'd0, 1'b0);
    tick();
    set_lvl(3'd0, 1'b1);
    tick();
    check("R6 enable low blocks capture", 1'b1);
    set_lvl(3'd0, 1'b0);
    pt_ind = 1'b1;
    tick();
    set_lvl(3'd0, 1'b1);
    tick();
    check("R6 enable high allows capture", 1'b0);
    cfg_ind_use = 2'd0; pt_ind = 1'b0;

    // R5: latch follows while high, holds while low
    cfg_mode = 2'd2; cfg_clk_sel = 3'd1; sum_in = 1'b1;
    set_lvl(3'd1, 1'b0);
    tick();
    check("R5 latch closed while low", 1'b0);
    set_lvl(3'd1, 1'b1);
    tick();
    check("R5 latch opens", 1'b1);
    sum_in = 1'b0;
    tick();
    check("R5 latch follows data", 1'b0);
    set_lvl(3'd1, 1'b0);
    sum_in = 1'b1;
    tick(); tick();
    check("R5 latch holds while low", 1'b0);

    // R7: shared preset and individual reset, no clock activity
    cfg_mode = 2'd0; cfg_clk_sel = 3'd0; set_lvl(3'd0, 1'b0);
    cfg_shr_act = 2'd2; pt_shr_init = 1'b1;
    tick();
    check("R7 shared preset", 1'b1);
    pt_shr_init = 1'b0; cfg_shr_act = 2'd0;
    cfg_ind_use = 2'd2; pt_ind = 1'b1;
    tick();
    check("R7 individual reset", 1'b0);
    pt_ind = 1'b0;

    // R8: reset, preset and a capture of 1 in one cycle
    sum_in = 1'b1;
    set_lvl(3'd0, 1'b0);
    tick();
    cfg_shr_act = 2'd2; pt_shr_init = 1'b1; pt_ind = 1'b1;
    set_lvl(3'd0, 1'b1);
    tick();
    check("R8 reset beats preset and capture", 1'b0);
    pt_ind = 1'b0;
    tick();
    check("R8 R7 preset alone after reset drops", 1'b1);
    pt_shr_init = 1'b0; cfg_shr_act = 2'd0; cfg_ind_use = 2'd0;

    // R9: init value 1, source high when reset ends is no edge
    sum_in = 1'b0;
    set_lvl(3'd0, 1'b0);
    tick();
    set_lvl(3'd0, 1'b1);
    tick();
    check("R3 capture 0 before reset", 1'b0);
    cfg_init_val = 1'b1;
    rst = 1'b1;
    tick(); tick();
    check("R9 reset loads init value 1", 1'b1);
    rst = 1'b0;
    tick();
    check("R9 no edge from high source after reset", 1'b1);
    tick();
    check("R9 still no edge", 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule